// File: doc/BRIEF.md
# Transceiver Reset Sequencing Controller

This controller brings a network transceiver core out of reset. It runs on the reference clock and accepts three kinds of reset request. The first is a power-good indication, which acts as the power-on source. The second is an active-low external reset pin, which counts only once it has stayed low long enough. The third is a management write that sets a self-clearing software reset bit. The controller drives the core reset and pulses a load-defaults strobe towards the register file. It also reports readiness in two steps: first the management port, then the MAC-side interface.

After every reset the controller first runs a fixed, short initialization count. When that count ends, the management port becomes usable and the register file reloads its defaults. The MAC side stays unavailable until the transmit and receive clocks are reported valid. If they do not become valid within a configurable window, the initialization count runs again. A new reset request at any point restarts the sequence from the beginning.

Top module: `xcvr_rst_seq`

## Requirements
- R1: The reset pin becomes a hardware reset request only after its synchronized value (SYNC_STAGES flops, default 2) has been low for MIN_LOW_CYCLES (default 5) consecutive clocks. A shorter low pulse has no effect on any output. With default parameters, the management-ready flag falls exactly 8 clocks after the pin goes low.
- R2: While a qualified pin reset or a power-on hold is active, core reset is high, both ready flags are low and the load-defaults strobe is low.
- R3: Each initialization phase keeps core reset high for exactly INIT_CYCLES (default 16) clocks. After that, core reset falls and management-ready rises in the same clock. With default parameters, management-ready rises 20 clocks after the pin returns high.
- R4: MAC-ready rises in the clock after clocks-valid is sampled high while the management port is ready. It falls in the clock after clocks-valid is sampled low, and management-ready stays high when it does.
- R5: If clocks-valid is not seen for CLK_TIMEOUT_CYCLES consecutive clocks while management-ready is high, the initialization phase runs again. Management-ready then falls and returns INIT_CYCLES clocks later.
- R6: While power-good is low, the block holds core reset high and the other four outputs low. After power-good rises, the hold lasts POR_HOLD_CYCLES clocks and the normal exit follows. Management-ready therefore rises POR_HOLD_CYCLES + INIT_CYCLES + 1 clocks after release.
- R7: The reset pin is ignored for the whole power-on hold. A low level that covers the hold does not stretch it.
- R8: A software reset write is accepted only while management-ready is high. An accepted write sets the software reset bit output and starts an initialization phase. The bit clears itself when management-ready returns. A write at any other time changes nothing.
- R9: The software reset bit is never set by a pin reset or a power-on reset.
- R10: The load-defaults strobe is a single-clock pulse. It is high in the first clock of every management-ready period that follows an initialization phase.
- R11: A new accepted request in any phase restarts the sequence. The management-ready and MAC-ready flags fall in the clock after the request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| pwr_good_i | input | 1 | Power-good indication, low while supply is not valid (asynchronous reset of the block) |
| pin_rst_n_i | input | 1 | External reset pin, active low, asynchronous to clk_i |
| sw_rst_wr_i | input | 1 | Management write that sets the software reset bit |
| clks_valid_i | input | 1 | Transmit and receive clocks reported valid |
| core_rst_o | output | 1 | Reset to the transceiver core, active high |
| sw_rst_bit_o | output | 1 | Self-clearing software reset control bit |
| mgmt_ready_o | output | 1 | Management port usable |
| mac_ready_o | output | 1 | MAC-side interface usable, reset cycle complete |
| load_defaults_o | output | 1 | One-clock strobe telling the register file to reload defaults |

## Verification
The assertions check the following on every clock:
- A request always forces core reset and drops both ready flags in the next clock.
- The software bit only rises from an accepted write.
- The load-defaults strobe is a one-clock pulse that follows core reset.
- MAC-ready only rises after clocks-valid was seen.
- The pin qualifier never fires while the power-on hold blocks it.

Exact cycle counts can only be shown by the bench's scenarios: the 8-clock pin qualification latency, the 16-clock initialization, the power-on hold length and the clocks-valid timeout window. The same holds for the boundary between 4-clock and 5-clock pin pulses and for the case where a low pin spans the end of the power-on hold.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_INIT = 2'd1,
        ST_WAIT = 2'd2,
        ST_UP   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/xrs_pin_qual.sv
module xrs_pin_qual #(
    parameter int MIN_LOW     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic pin_n_i,
    input  logic block_i,
    output logic qual_o
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(MIN_LOW);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
    } pq_state_t;

    pq_state_t q, d;
    logic      pin_synced;

    assign pin_synced = q.sync[SYNC_STAGES-1];

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], pin_n_i};
        if (block_i || pin_synced) begin
            d.cnt = '0;
        end else if (q.cnt != CNT_MAX) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            q.sync <= '1;
            q.cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign qual_o = (q.cnt == CNT_MAX);

    // R1: a qualified request always follows a low synchronized pin sample
    a_r1_qual_needs_low: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        qual_o |-> ($past(!pin_synced) && !$past(block_i)));

    // R7: a blocked cycle never leaves a qualified request behind
    a_r7_blocked_pin: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        block_i |=> !qual_o);

endmodule

// File: rtl/xrs_por_hold.sv
module xrs_por_hold #(
    parameter int HOLD_CYCLES = 500
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic busy_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
    } por_state_t;

    por_state_t q, d;

    always_comb begin
        d = q;
        if (q.busy) begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == LAST) begin
                d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            q.cnt  <= '0;
            q.busy <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.busy;

    // R6: once the power-on hold ends it stays ended until power drops
    a_r6_hold_ends_once: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !busy_o |=> !busy_o);

endmodule

// File: rtl/xrs_seq_fsm.sv
module xrs_seq_fsm
    import xrs_pkg::*;
#(
    parameter int INIT_CYCLES = 16,
    parameter int CLK_TIMEOUT = 2_000_000
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic hold_req_i,
    input  logic sw_wr_i,
    input  logic clks_valid_i,
    output logic core_rst_o,
    output logic mgmt_ready_o,
    output logic mac_ready_o,
    output logic load_def_o,
    output logic sw_bit_o
);
    localparam int ICW = $clog2(INIT_CYCLES + 1);
    localparam int TCW = $clog2(CLK_TIMEOUT + 1);
    localparam logic [ICW-1:0] INIT_LAST = ICW'(INIT_CYCLES - 1);
    localparam logic [TCW-1:0] TMO_LAST  = TCW'(CLK_TIMEOUT - 1);

    typedef struct packed {
        seq_state_e     state;
        logic [ICW-1:0] icnt;
        logic [TCW-1:0] tcnt;
        logic           load;
        logic           swbit;
    } fsm_state_t;

    fsm_state_t q, d;
    logic       ready_now;

    assign ready_now = (q.state == ST_WAIT) || (q.state == ST_UP);

    always_comb begin
        d      = q;
        d.load = 1'b0;
        unique case (q.state)
            ST_HOLD: begin
                if (!hold_req_i) begin
                    d.state = ST_INIT;
                    d.icnt  = '0;
                end
            end
            ST_INIT: begin
                if (q.icnt == INIT_LAST) begin
                    d.state = ST_WAIT;
                    d.tcnt  = '0;
                    d.load  = 1'b1;
                    d.swbit = 1'b0;
                end else begin
                    d.icnt = q.icnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (clks_valid_i) begin
                    d.state = ST_UP;
                end else if (q.tcnt == TMO_LAST) begin
                    d.state = ST_INIT;
                    d.icnt  = '0;
                end else begin
                    d.tcnt = q.tcnt + 1'b1;
                end
            end
            ST_UP: begin
                if (!clks_valid_i) begin
                    d.state = ST_WAIT;
                    d.tcnt  = '0;
                end
            end
            default: d.state = ST_HOLD;
        endcase

        if (hold_req_i) begin
            d.state = ST_HOLD;
            d.load  = 1'b0;
        end else if (sw_wr_i && ready_now) begin
            d.state = ST_INIT;
            d.icnt  = '0;
            d.swbit = 1'b1;
            d.load  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            q.state <= ST_HOLD;
            q.icnt  <= '0;
            q.tcnt  <= '0;
            q.load  <= 1'b0;
            q.swbit <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign core_rst_o   = (q.state == ST_HOLD) || (q.state == ST_INIT);
    assign mgmt_ready_o = ready_now;
    assign mac_ready_o  = (q.state == ST_UP);
    assign load_def_o   = q.load;
    assign sw_bit_o     = q.swbit;

    // R11 / R2: a hardware or power-on request takes effect in the next clock
    a_r11_hold_restarts: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        hold_req_i |=> (core_rst_o && !mgmt_ready_o && !mac_ready_o && !load_def_o));

    // R8: an accepted software write restarts initialization and sets the bit
    a_r8_sw_restarts: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (sw_wr_i && mgmt_ready_o && !hold_req_i) |=> (core_rst_o && !mgmt_ready_o && sw_bit_o));

    // R9: the bit only ever rises from an accepted write
    a_r9_bit_source: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(sw_bit_o) |-> ($past(sw_wr_i) && $past(mgmt_ready_o)));

    // R10: load-defaults is one clock long and follows core reset
    a_r10_load_single: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        load_def_o |=> !load_def_o);
    a_r10_load_after_init: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        load_def_o |-> (mgmt_ready_o && $past(core_rst_o)));

    // R4: MAC side only comes up after clocks-valid was sampled
    a_r4_mac_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(mac_ready_o) |-> $past(clks_valid_i));

    // R3: core reset release coincides with the management port becoming ready
    a_r3_release_ready: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(core_rst_o) |-> mgmt_ready_o);

endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq #(
    parameter int MIN_LOW_CYCLES     = 5,
    parameter int SYNC_STAGES        = 2,
    parameter int INIT_CYCLES        = 16,
    parameter int POR_HOLD_CYCLES    = 500,
    parameter int CLK_TIMEOUT_CYCLES = 2_000_000
) (
    input  logic clk_i,
    input  logic pwr_good_i,
    input  logic pin_rst_n_i,
    input  logic sw_rst_wr_i,
    input  logic clks_valid_i,
    output logic core_rst_o,
    output logic sw_rst_bit_o,
    output logic mgmt_ready_o,
    output logic mac_ready_o,
    output logic load_defaults_o
);
    logic por_busy;
    logic pin_qual;
    logic hold_req;

    xrs_por_hold #(
        .HOLD_CYCLES (POR_HOLD_CYCLES)
    ) u_por (
        .clk_i   (clk_i),
        .rst_n_i (pwr_good_i),
        .busy_o  (por_busy)
    );

    xrs_pin_qual #(
        .MIN_LOW     (MIN_LOW_CYCLES),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_pin (
        .clk_i   (clk_i),
        .rst_n_i (pwr_good_i),
        .pin_n_i (pin_rst_n_i),
        .block_i (por_busy),
        .qual_o  (pin_qual)
    );

    assign hold_req = pin_qual | por_busy;

    xrs_seq_fsm #(
        .INIT_CYCLES (INIT_CYCLES),
        .CLK_TIMEOUT (CLK_TIMEOUT_CYCLES)
    ) u_fsm (
        .clk_i        (clk_i),
        .rst_n_i      (pwr_good_i),
        .hold_req_i   (hold_req),
        .sw_wr_i      (sw_rst_wr_i),
        .clks_valid_i (clks_valid_i),
        .core_rst_o   (core_rst_o),
        .mgmt_ready_o (mgmt_ready_o),
        .mac_ready_o  (mac_ready_o),
        .load_def_o   (load_defaults_o),
        .sw_bit_o     (sw_rst_bit_o)
    );

    // R7: the power-on hold keeps the pin qualifier silent
    a_r7_por_masks_pin: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        por_busy |=> !pin_qual);

endmodule

// File: tb/xcvr_rst_seq_test.sv
`timescale 1ns/1ps
module xcvr_rst_seq_test;
    localparam int MIN_LOW = 5;
    localparam int SYNC    = 2;
    localparam int INIT    = 16;
    localparam int POR     = 40;
    localparam int TMO     = 200;

    logic clk = 1'b0;
    logic pwr_good, pin_n, sw_wr, clks_valid;
    logic core_rst, sw_bit, mgmt_rdy, mac_rdy, load_def;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    xcvr_rst_seq #(
        .MIN_LOW_CYCLES     (MIN_LOW),
        .SYNC_STAGES        (SYNC),
        .INIT_CYCLES        (INIT),
        .POR_HOLD_CYCLES    (POR),
        .CLK_TIMEOUT_CYCLES (TMO)
    ) uut (
        .clk_i           (clk),
        .pwr_good_i      (pwr_good),
        .pin_rst_n_i     (pin_n),
        .sw_rst_wr_i     (sw_wr),
        .clks_valid_i    (clks_valid),
        .core_rst_o      (core_rst),
        .sw_rst_bit_o    (sw_bit),
        .mgmt_ready_o    (mgmt_rdy),
        .mac_ready_o     (mac_rdy),
        .load_defaults_o (load_def)
    );

    function automatic bit exp_pin_hit(input int len);
        return len >= MIN_LOW;
    endfunction
    function automatic int exp_pin_drop_lat();
        return SYNC + MIN_LOW + 1;
    endfunction
    function automatic int exp_pin_release_lat();
        return SYNC + 2 + INIT;
    endfunction
    function automatic int exp_por_lat();
        return POR + INIT + 1;
    endfunction

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_mac_ready(input string req);
        int n = 0;
        while (!mac_rdy && n < 400) begin
            tick();
            n++;
        end
        check_eq(req, "recovered to mac ready", int'(mac_rdy), 1);
    endtask

    task automatic pin_pulse(input int len, output bit dropped);
        dropped = 1'b0;
        pin_n = 1'b0;
        for (int i = 0; i < len; i++) begin
            tick();
            if (!mgmt_rdy) dropped = 1'b1;
        end
        pin_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            tick();
            if (!mgmt_rdy) dropped = 1'b1;
        end
    endtask

    task automatic sw_reset_check(input string req);
        int n;
        sw_wr = 1'b1;
        tick();
        sw_wr = 1'b0;
        check_eq(req, "sw core reset asserted", int'(core_rst), 1);
        check_eq("R11", "sw restart drops mgmt", int'(mgmt_rdy), 0);
        check_eq("R11", "sw restart drops mac", int'(mac_rdy), 0);
        check_eq(req, "sw bit set", int'(sw_bit), 1);
        n = 1;
        tick();
        while (core_rst && n < 100) begin
            n++;
            tick();
        end
        check_eq("R3", "sw init length", n, INIT);
        check_eq(req, "mgmt after sw init", int'(mgmt_rdy), 1);
        check_eq("R10", "load strobe after sw", int'(load_def), 1);
        check_eq(req, "sw bit self-cleared", int'(sw_bit), 0);
        tick();
        check_eq("R10", "load strobe one clock", int'(load_def), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int seed_dummy;
        bit dropped;
        seed_dummy = $urandom(32'd20240611);
        pwr_good = 1'b0; pin_n = 1'b1; sw_wr = 1'b0; clks_valid = 1'b0;
        repeat (3) tick();
        // R6: reset state
        check_eq("R6", "core reset in power-down", int'(core_rst), 1);
        check_eq("R6", "mgmt low in power-down", int'(mgmt_rdy), 0);
        check_eq("R6", "mac low in power-down", int'(mac_rdy), 0);
        check_eq("R6", "load low in power-down", int'(load_def), 0);
        check_eq("R9", "bit low in power-down", int'(sw_bit), 0);

        // R6: power-on hold then exit
        pwr_good = 1'b1;
        n = 0;
        do begin tick(); n++; end while (!mgmt_rdy && n < 300);
        check_eq("R6", "power-on latency", n, exp_por_lat());
        check_eq("R3", "core reset released", int'(core_rst), 0);
        check_eq("R10", "load after power-on", int'(load_def), 1);
        check_eq("R9", "bit after power-on", int'(sw_bit), 0);
        tick();
        check_eq("R10", "load pulse width", int'(load_def), 0);

        // R4: mac side follows clocks-valid
        repeat (5) tick();
        check_eq("R4", "mac low without valid", int'(mac_rdy), 0);
        clks_valid = 1'b1;
        tick();
        check_eq("R4", "mac rises after valid", int'(mac_rdy), 1);
        clks_valid = 1'b0;
        tick();
        check_eq("R4", "mac falls after valid drop", int'(mac_rdy), 0);
        check_eq("R4", "mgmt kept on valid drop", int'(mgmt_rdy), 1);

        // R5: timeout reruns initialization
        n = 1;
        tick();
        while (mgmt_rdy && n < 1000) begin n++; tick(); end
        check_eq("R5", "timeout window", n, TMO);
        check_eq("R5", "core reset on timeout", int'(core_rst), 1);
        n = 0;
        do begin tick(); n++; end while (!mgmt_rdy && n < 100);
        check_eq("R5", "reinit length after timeout", n, INIT);
        check_eq("R10", "load after timeout reinit", int'(load_def), 1);
        clks_valid = 1'b1;
        tick();
        check_eq("R4", "mac up again", int'(mac_rdy), 1);

        // R1: four-clock pulse ignored
        pin_pulse(4, dropped);
        check_eq("R1", "4-clock pulse ignored", int'(dropped), 0);
        check_eq("R1", "mac kept after short pulse", int'(mac_rdy), 1);

        // R1 / R11: exact qualification latency, R2 held state
        pin_n = 1'b0;
        n = 0;
        do begin tick(); n++; end while (mgmt_rdy && n < 50);
        check_eq("R1", "pin drop latency", n, exp_pin_drop_lat());
        check_eq("R11", "mac dropped on pin", int'(mac_rdy), 0);
        repeat (20) tick();
        check_eq("R2", "core reset while pin held", int'(core_rst), 1);
        check_eq("R2", "mgmt low while pin held", int'(mgmt_rdy), 0);
        check_eq("R2", "load low while pin held", int'(load_def), 0);
        check_eq("R9", "bit low during pin reset", int'(sw_bit), 0);

        // R3: release latency; R8: write while not ready is ignored
        pin_n = 1'b1;
        n = 0;
        do begin
            if (n == 6) sw_wr = 1'b1;
            if (n == 7) sw_wr = 1'b0;
            tick();
            n++;
        end while (!mgmt_rdy && n < 100);
        sw_wr = 1'b0;
        check_eq("R3", "pin release latency", n, exp_pin_release_lat());
        check_eq("R8", "write during init ignored", int'(sw_bit), 0);
        wait_mac_ready("R4");

        // R8: software reset from ready
        sw_reset_check("R8");
        wait_mac_ready("R8");

        // R7: pin low across the power-on hold
        pwr_good = 1'b0; pin_n = 1'b0; clks_valid = 1'b0;
        repeat (3) tick();
        pwr_good = 1'b1;
        n = 0;
        do begin
            tick();
            n++;
            if (n == POR) pin_n = 1'b1;
        end while (!mgmt_rdy && n < 300);
        pin_n = 1'b1;
        check_eq("R7", "pin ignored during hold", n, exp_por_lat());
        check_eq("R9", "bit after pin-masked power-on", int'(sw_bit), 0);
        clks_valid = 1'b1;
        wait_mac_ready("R7");

        // Random pulses and software resets
        for (int it = 0; it < 24; it++) begin
            int len;
            len = 1 + int'($urandom_range(7, 0));
            if ($urandom_range(3, 0) == 0) begin
                sw_reset_check("R8");
                wait_mac_ready("R8");
            end
            pin_pulse(len, dropped);
            check_eq("R1", $sformatf("random pulse len %0d", len), int'(dropped),
                     int'(exp_pin_hit(len)));
            if (dropped) wait_mac_ready("R11");
            repeat (int'($urandom_range(5, 1))) tick();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule